// File: doc/BRIEF.md
# Vertical Scaler with Anti-Flicker Blending

This block takes progressive pictures line by line and produces interlaced output fields. A single datapath does three jobs: it reduces the number of lines, it softens flicker by mixing each emitted line with the line above it, and it turns frames into fields. A phase accumulator steps once per input line. Each time it crosses a whole line it emits an output line, and the fractional remainder becomes the mixing weight. The odd and even fields start from different programmable initial weights, so the two fields sample the same frame at different vertical positions.

The first line of each frame is a border line. It is only stored, so that the first real line has a neighbour to mix with. A single line store of programmable width keeps the previous input line. A strength control moves the mixing weight toward the current line, and its all-ones value turns mixing off completely.

Top module: `vert_flicker_scaler`

## Requirements
- R1: After reset, out_valid and cfg_err are 0.
- R2: A pixel with in_valid and in_sof starts a border line. The accumulator is loaded with the field's initial weight, and the samples of that line are stored but produce no output.
- R3: With cfg_yinc equal to 0 (a step of 4096), every non-border line produces one output pixel for each sample whose column is below the active width.
- R4: On each non-border line start, the step (cfg_yinc, or 4096 when cfg_yinc is 0) is added to the 12-bit accumulator. If the sum is 4096 or more, the line is emitted with raw weight sum-4096, and the accumulator becomes sum-4096. Otherwise the line is skipped and the accumulator becomes the sum.
- R5: At a frame start, in_field_odd=1 selects cfg_iw_odd and in_field_odd=0 selects cfg_iw_even as the initial weight.
- R6: A selected initial weight of 0 is used as 1 and sets cfg_err. cfg_err stays set until reset.
- R7: An emitted sample equals (w*cur + (4096-w)*prev + 2048) >> 12. Here prev is the same column of the previous input line, whether or not that line was emitted.
- R8: The effective weight is w = raw + (((4096-raw)*cfg_yskip) >> 12). When cfg_yskip is 4095, w is 4096 and the output equals the current sample.
- R9: A sample whose column (counted from 0 at the line start) is not below both cfg_width and 64 is neither stored nor output.
- R10: out_valid rises in the cycle after the accepted input sample and only then. When no sample is accepted, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_sol | input | 1 | First sample of a line |
| in_sof | input | 1 | First sample of a frame (border line start) |
| in_field_odd | input | 1 | Field select, sampled at frame start |
| in_pix | input | 8 | Input sample |
| cfg_width | input | 7 | Active samples per line |
| cfg_yinc | input | 12 | Phase step per line, 0 means unity |
| cfg_iw_odd | input | 12 | Initial weight, odd field |
| cfg_iw_even | input | 12 | Initial weight, even field |
| cfg_yskip | input | 12 | Anti-flicker reduction, 4095 disables |
| out_valid | output | 1 | Output line-valid flag per sample |
| out_pix | output | 8 | Output sample |
| cfg_err | output | 1 | Sticky zero-weight configuration error |

## Verification
Unity-step frames with distinct odd and even weights show whether the field select and the per-line weight reach the mixer, and line counts confirm that every line is emitted. Frames with a fractional step show the skip pattern and the weight taken from the remainder, and sweeping the strength control up to its disable value shows the pull toward the current line. Overlong lines, a width change within a frame and a width above the store size separate correct column bounding from stray writes. Random configurations with random samples, plus a zero-weight frame, cover the general mix and the error flag.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

    localparam int PH_W = 12;
    localparam logic [PH_W:0]   PH_ONE   = {1'b1, {PH_W{1'b0}}};
    localparam logic [PH_W-1:0] SKIP_OFF = '1;

    typedef struct packed {
        logic [PH_W:0] acc;
        logic          emit;
        logic [PH_W:0] wt;
        logic          err;
    } phase_st_t;

    // pull a raw weight toward full weight by the skip fraction
    function automatic logic [PH_W:0] af_weight(input logic [PH_W:0]   raw,
                                                input logic [PH_W-1:0] skip);
        logic [PH_W:0]   gap;
        logic [2*PH_W:0] prod;
        gap  = PH_ONE - raw;
        prod = gap * skip;
        if (skip == SKIP_OFF) begin
            return PH_ONE;
        end
        return raw + prod[2*PH_W:PH_W];
    endfunction

endpackage

// File: rtl/vsc_phase.sv
module vsc_phase
    import vsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_go,
    input  logic            frame_go,
    input  logic            field_odd,
    input  logic [PH_W-1:0] yinc,
    input  logic [PH_W-1:0] iw_odd,
    input  logic [PH_W-1:0] iw_even,
    input  logic [PH_W-1:0] yskip,
    output logic            line_emit,
    output logic [PH_W:0]   line_wt,
    output logic            cfg_err
);

    phase_st_t st_q, st_d;

    logic [PH_W:0]   step;
    logic [PH_W-1:0] iw_sel, iw_eff;
    logic            iw_zero;
    logic [PH_W+1:0] sum, diff;
    logic            hit;
    logic [PH_W:0]   rem, raw, wt_now;

    always_comb begin
        step    = (yinc == '0) ? PH_ONE : {1'b0, yinc};
        iw_sel  = field_odd ? iw_odd : iw_even;
        iw_zero = (iw_sel == '0);
        iw_eff  = iw_zero ? PH_W'(1) : iw_sel;
        sum     = {1'b0, st_q.acc} + {1'b0, step};
        diff    = sum - {1'b0, PH_ONE};
        hit     = (sum >= {1'b0, PH_ONE});
        rem     = hit ? diff[PH_W:0] : sum[PH_W:0];
        raw     = hit ? diff[PH_W:0] : '0;
        wt_now  = af_weight(raw, yskip);

        st_d = st_q;
        if (line_go) begin
            if (frame_go) begin
                st_d.acc  = {1'b0, iw_eff};
                st_d.emit = 1'b0;
                st_d.err  = st_q.err | iw_zero;
            end else begin
                st_d.acc  = rem;
                st_d.emit = hit;
            end
            st_d.wt = wt_now;
        end

        line_emit = line_go ? (!frame_go && hit) : st_q.emit;
        line_wt   = line_go ? wt_now : st_q.wt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_err = st_q.err;

    // R4: the accumulator never holds a whole line
    a_r4_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < PH_ONE);

    // R6: the error flag only clears by reset
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

endmodule

// File: rtl/vsc_linebuf.sv
module vsc_linebuf #(
    parameter  int PIX_W = 8,
    parameter  int MAX_W = 64,
    localparam int CW    = $clog2(MAX_W + 1),
    localparam int AW    = $clog2(MAX_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_go,
    input  logic             line_go,
    input  logic [CW-1:0]    width,
    input  logic [PIX_W-1:0] wr_pix,
    output logic [PIX_W-1:0] rd_pix,
    output logic             in_range
);

    logic [CW-1:0]    col_q, col_d, col_now;
    logic [PIX_W-1:0] mem [MAX_W];

    always_comb begin
        col_now  = line_go ? '0 : col_q;
        in_range = (col_now < width) && (col_now < CW'(MAX_W));
        rd_pix   = mem[col_now[AW-1:0]];
        col_d    = col_q;
        if (pix_go) begin
            col_d = (col_now == CW'(MAX_W)) ? col_now : col_now + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    always_ff @(posedge clk) begin
        if (pix_go && in_range) begin
            mem[col_now[AW-1:0]] <= wr_pix;
        end
    end

    // R9: the column counter saturates at the store size
    a_r9_col_sat: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= CW'(MAX_W));

endmodule

// File: rtl/vsc_blend.sv
module vsc_blend
    import vsc_pkg::*;
#(
    parameter  int PIX_W = 8,
    localparam int MW    = PH_W + PIX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [PIX_W-1:0] cur,
    input  logic [PIX_W-1:0] prev,
    input  logic [PH_W:0]    wt,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] pix;
    } blend_st_t;

    blend_st_t     st_q, st_d;
    logic [MW-1:0] mix;

    always_comb begin
        mix = MW'(wt) * MW'(cur)
            + MW'(PH_ONE - wt) * MW'(prev)
            + MW'(PH_ONE >> 1);
        st_d       = st_q;
        st_d.valid = go;
        if (go) begin
            st_d.pix = mix[PH_W +: PIX_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_pix   = st_q.pix;

    // R8: full weight passes the current sample unchanged
    a_r8_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (go && wt == PH_ONE) |=> (out_pix == $past(cur)));

endmodule

// File: rtl/vert_flicker_scaler.sv
module vert_flicker_scaler
    import vsc_pkg::*;
#(
    parameter  int PIX_W = 8,
    parameter  int MAX_W = 64,
    localparam int CW    = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic             in_sof,
    input  logic             in_field_odd,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [CW-1:0]    cfg_width,
    input  logic [PH_W-1:0]  cfg_yinc,
    input  logic [PH_W-1:0]  cfg_iw_odd,
    input  logic [PH_W-1:0]  cfg_iw_even,
    input  logic [PH_W-1:0]  cfg_yskip,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    output logic             cfg_err
);

    logic             line_go, frame_go, line_emit, in_range, mix_go;
    logic [PH_W:0]    line_wt;
    logic [PIX_W-1:0] prev_pix;

    assign line_go  = in_valid & (in_sol | in_sof);
    assign frame_go = in_valid & in_sof;
    assign mix_go   = in_valid & in_range & line_emit;

    vsc_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_go   (line_go),
        .frame_go  (frame_go),
        .field_odd (in_field_odd),
        .yinc      (cfg_yinc),
        .iw_odd    (cfg_iw_odd),
        .iw_even   (cfg_iw_even),
        .yskip     (cfg_yskip),
        .line_emit (line_emit),
        .line_wt   (line_wt),
        .cfg_err   (cfg_err)
    );

    vsc_linebuf #(.PIX_W(PIX_W), .MAX_W(MAX_W)) u_lbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_go   (in_valid),
        .line_go  (line_go),
        .width    (cfg_width),
        .wr_pix   (in_pix),
        .rd_pix   (prev_pix),
        .in_range (in_range)
    );

    vsc_blend #(.PIX_W(PIX_W)) u_blend (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (mix_go),
        .cur       (in_pix),
        .prev      (prev_pix),
        .wt        (line_wt),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    // R10: an output sample always follows an accepted input sample
    a_r10_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R2: the border line start yields no output
    a_r2_border_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> !out_valid);

    // R3: at unity step a non-border line start is always emitted
    a_r3_unity_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol && !in_sof && cfg_yinc == '0 && cfg_width != '0)
        |=> out_valid);

endmodule

// File: tb/vert_flicker_scaler_tb.sv
module vert_flicker_scaler_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_sol, in_sof, in_field_odd;
    logic [7:0]  in_pix;
    logic [6:0]  cfg_width;
    logic [11:0] cfg_yinc, cfg_iw_odd, cfg_iw_even, cfg_yskip;
    logic        out_valid, cfg_err;
    logic [7:0]  out_pix;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int m_acc, m_wt, m_col;
    bit m_emit, m_err;
    int m_buf [64];

    always #10 clk = ~clk;

    vert_flicker_scaler u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_sof(in_sof), .in_field_odd(in_field_odd), .in_pix(in_pix),
        .cfg_width(cfg_width), .cfg_yinc(cfg_yinc), .cfg_iw_odd(cfg_iw_odd),
        .cfg_iw_even(cfg_iw_even), .cfg_yskip(cfg_yskip),
        .out_valid(out_valid), .out_pix(out_pix), .cfg_err(cfg_err)
    );

    function automatic int af_w(int raw, int skip);
        if (skip == 4095) return 4096;
        return raw + (((4096 - raw) * skip) >> 12);
    endfunction

    function automatic int mix_m(int w, int c, int p);
        return (w * c + (4096 - w) * p + 2048) >> 12;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step_pix(bit v, bit sol, bit sof, bit fld, int p,
                            string tag, inout int nout);
        int    exp_v, exp_p, iw, stp, sum;
        bit    inr;
        string t;
        exp_v = 0; exp_p = 0; inr = 1; t = tag;
        in_valid = v; in_sol = sol; in_sof = sof; in_field_odd = fld;
        in_pix = p[7:0];
        if (v) begin
            if (sol || sof) m_col = 0;
            if (sof) begin
                iw = fld ? int'(cfg_iw_odd) : int'(cfg_iw_even);
                if (iw == 0) begin iw = 1; m_err = 1; end
                m_acc = iw; m_emit = 0;
            end else if (sol) begin
                stp = (cfg_yinc == 0) ? 4096 : int'(cfg_yinc);
                sum = m_acc + stp;
                if (sum >= 4096) begin
                    m_emit = 1; m_acc = sum - 4096; m_wt = af_w(m_acc, int'(cfg_yskip));
                end else begin
                    m_emit = 0; m_acc = sum;
                end
            end
            inr = (m_col < int'(cfg_width)) && (m_col < 64);
            exp_v = (inr && m_emit) ? 1 : 0;
            if (inr) begin
                exp_p = mix_m(m_wt, p, m_buf[m_col]);
                m_buf[m_col] = p;
            end
            if (m_col < 64) m_col++;
            if (sof) t = "R2";
            if (!inr) t = "R9";
        end
        @(posedge clk);
        @(negedge clk);
        chk(t, int'(out_valid), exp_v);
        if (exp_v != 0) chk(t, int'(out_pix), exp_p);
        chk("R6", int'(cfg_err), int'(m_err));
        if (out_valid) nout++;
    endtask

    task automatic send_line(bit sof, bit fld, int n, string tag, output int nout);
        int dummy = 0;
        nout = 0;
        for (int i = 0; i < n; i++)
            step_pix(1, i == 0, sof && i == 0, fld, int'($urandom % 256), tag, nout);
        step_pix(0, 0, 0, fld, 0, "R10", dummy);
    endtask

    task automatic send_frame(bit fld, int lines, int n, string tag, bit cnt_chk);
        int cnt, expn;
        send_line(1, fld, n, tag, cnt);
        chk("R2", cnt, 0);
        for (int l = 0; l < lines; l++) begin
            send_line(0, fld, n, tag, cnt);
            if (cnt_chk) begin
                expn = (n < int'(cfg_width)) ? n : int'(cfg_width);
                if (expn > 64) expn = 64;
                chk("R3", cnt, expn);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'd20240611));
        m_acc = 0; m_wt = 0; m_col = 0; m_emit = 0; m_err = 0;
        for (int i = 0; i < 64; i++) m_buf[i] = 0;
        rst_n = 0; in_valid = 0; in_sol = 0; in_sof = 0; in_field_odd = 0;
        in_pix = 0; cfg_width = 7'd16; cfg_yinc = 0; cfg_iw_odd = 12'd1024;
        cfg_iw_even = 12'd3000; cfg_yskip = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(cfg_err), 0);
        rst_n = 1;

        // unity step, odd then even field weights
        send_frame(1, 4, 16, "R7", 1);
        send_frame(0, 4, 16, "R5", 1);
        send_frame(1, 2, 16, "R5", 1);

        // anti-flicker strength
        cfg_yskip = 12'd2000;
        send_frame(0, 3, 16, "R8", 1);
        cfg_yskip = 12'd4095;
        send_frame(1, 3, 16, "R8", 1);
        cfg_yskip = 12'd4094;
        send_frame(0, 2, 16, "R8", 1);

        // fractional steps
        cfg_yskip = 0; cfg_yinc = 12'd1500;
        send_frame(1, 9, 16, "R4", 0);
        cfg_yinc = 12'd4095; cfg_iw_even = 12'd7;
        send_frame(0, 5, 16, "R4", 0);
        cfg_yinc = 12'd1;
        send_frame(1, 3, 8, "R4", 0);

        // width bounding, width change inside a frame, width above store
        cfg_yinc = 0; cfg_width = 7'd10;
        send_line(1, 1, 14, "R9", cnt);
        send_line(0, 1, 14, "R9", cnt);
        chk("R9", cnt, 10);
        cfg_width = 7'd16;
        send_line(0, 1, 16, "R9", cnt);
        chk("R9", cnt, 16);
        cfg_width = 7'd100;
        send_frame(0, 2, 68, "R9", 1);

        // random configurations
        for (int f = 0; f < 12; f++) begin
            cfg_width   = 7'(1 + $urandom % 64);
            cfg_yinc    = ($urandom % 3 == 0) ? 12'd0 : 12'($urandom % 4096);
            cfg_iw_odd  = 12'(1 + $urandom % 4095);
            cfg_iw_even = 12'(1 + $urandom % 4095);
            cfg_yskip   = 12'($urandom % 4096);
            send_frame(f[0], 1 + int'($urandom % 6), int'(cfg_width) + int'($urandom % 4),
                       "R7", cfg_yinc == 0);
        end

        // zero initial weight
        cfg_width = 7'd12; cfg_yinc = 0; cfg_yskip = 0; cfg_iw_even = 0;
        send_frame(0, 3, 12, "R6", 1);
        chk("R6", int'(cfg_err), 1);
        cfg_iw_even = 12'd2048;
        send_frame(0, 2, 12, "R6", 1);
        chk("R6", int'(cfg_err), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule